// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns a graphics aperture bus address into a physical memory address. The translation uses two levels. The first level is a 64-entry directory held on chip. Each directory entry covers 4 MiB of aperture and points to a 4 KiB second-level page in memory. That page holds 1024 page entries of 32 bits each. Software fills the directory one entry at a time through a single packed 32-bit load port. The block reads second-level entries from memory on demand. It keeps the most recently used ones in a small fully associative translation cache.

Requests arrive on a valid/ready port, and the block handles one request at a time. A request that is accepted is held until its response has been taken. Back-pressure works in two places. When the downstream side holds `rsp_ready_i` low, the response stays on the port unchanged. When `mem_req_ready_i` is low, the memory read request stays on the port unchanged. The memory response has no ready signal: the block always takes it in the cycle it is valid.

Software flushes the translation cache by writing the control port twice. The first write clears control bit 7 and the second sets it. While a flush is pending, the block accepts no new requests.

Top module: `aper_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` and `mem_req_valid_o` are 0. No directory entry is present and the cache holds nothing, so the first request to any page faults without issuing a memory read.
- R2: A directory load write uses bits 5:0 as the entry index, bit 8 as the present flag and bits 31:12 as the second-level page address. Bits 11:6 have no effect on translation. A load with bit 8 clear makes that entry not present, and a request that maps to a non-present entry faults without a memory read.
- R3: The directory index of a request is `addr[31:22] - base[31:22]`, computed modulo 1024. The size code selects how many directory entries are in range: code 0 gives 64, code 32 gives 32, code 48 gives 16 and code 56 gives 8. Any other code leaves no entry in range. An index at or above the limit faults without a memory read, even when the page is cached.
- R4: On a cache miss the block issues exactly one memory read at address `{table[31:12], addr[21:12], 2'b00}`.
- R5: A second-level entry with bit 0 set gives the result `{entry[31:12], addr[11:0]}`. An entry with bit 0 clear gives a fault.
- R6: A fault response has `rsp_fault_o` = 1 and `rsp_addr_o` = 0.
- R7: The cache has four entries. A hit returns the result without a memory read. Only valid second-level entries are stored. A fill replaces entries in round-robin order.
- R8: Writing the control port with bit 7 going from 0 to 1 flushes the cache; the usual sequence is 0x2200 then 0x2280. Writing bit 7 as 1 again while it is already 1 does not flush. While a flush is pending, `req_ready_o` is 0.
- R9: From acceptance until its response is taken, `req_ready_o` is 0. The response and the memory read request stay stable until they are taken.
- R10: A hit or a fault raises `rsp_valid_o` at the first rising edge after the accepting edge. A miss raises `mem_req_valid_o` at that same edge. For a miss, `rsp_valid_o` rises at the edge that samples `mem_rsp_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base_i | input | 32 | Aperture base address (bits 31:22 used) |
| cfg_size_i | input | 8 | Aperture size code |
| dir_wr_i | input | 1 | Directory load strobe |
| dir_wdata_i | input | 32 | Packed directory load value |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 32 | Control value (bit 7 is the flush trigger) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Translation request ready |
| req_addr_i | input | 32 | Aperture bus address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_addr_o | output | 32 | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Translation fault |
| mem_req_valid_o | output | 1 | Second-level read request valid |
| mem_req_ready_i | input | 1 | Memory read request ready |
| mem_req_addr_o | output | 32 | Second-level entry address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | 32 | Second-level entry |

## Verification
If a request is accepted at edge E0, a hit or a fault shows `rsp_valid_o` at E1. A miss instead shows `mem_req_valid_o` at E1. With `mem_req_ready_i` held high, the read handshake completes at E2. The bench then drives `mem_rsp_valid_i` for one cycle, and the response appears at the edge that samples it. A flush pending flag appears one edge after the control write and holds `req_ready_o` low for one cycle. The bench drives all inputs at falling edges and samples every one of these results at the falling edge that follows the edge where the result is due. It does not poll for a result, so a response one cycle early or late is reported.

// File: rtl/xl_pkg.sv
package xl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_MREQ, ST_MWAIT, ST_RESP
  } xl_state_t;

  // number of directory entries in range for a size code
  function automatic logic [7:0] size_limit(input logic [7:0] code, input int dir_n);
    logic [7:0] lim;
    case (code)
      8'd0:    lim = 8'(dir_n);
      8'd32:   lim = 8'(dir_n >> 1);
      8'd48:   lim = 8'(dir_n >> 2);
      8'd56:   lim = 8'(dir_n >> 3);
      default: lim = 8'd0;
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/xl_dir.sv
module xl_dir #(
  parameter int ENTRIES = 64,
  parameter int TBL_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_present,
  input  logic [TBL_W-1:0] wr_tbl,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_present,
  output logic [TBL_W-1:0] rd_tbl
);
  logic [ENTRIES-1:0] present_q;
  logic [TBL_W-1:0]   tbl_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     present_q[g] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(g))          present_q[g] <= wr_present;
    end
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) tbl_q[g] <= wr_tbl;
    end
  end

  assign rd_present = present_q[rd_idx];
  assign rd_tbl     = tbl_q[rd_idx];
endmodule

// File: rtl/xl_tcache.sv
module xl_tcache #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 20,
  localparam int PTR_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  logic [WAYS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [WAYS];
  logic [DATA_W-1:0] data_q [WAYS];
  logic [PTR_W-1:0]  ptr_q;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    vld_q[g] <= 1'b0;
      else if (flush)                                vld_q[g] <= 1'b0;
      else if (fill_en && ptr_q == PTR_W'(g))        vld_q[g] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (fill_en && ptr_q == PTR_W'(g)) begin
        tag_q[g]  <= fill_tag;
        data_q[g] <= fill_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (fill_en) ptr_q <= ptr_q + 1'b1;
  end

  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[w] && tag_q[w] == lk_tag && !lk_hit) begin
        lk_hit  = 1'b1;
        lk_data = data_q[w];
      end
    end
  end
endmodule

// File: rtl/aper_xlate.sv
module aper_xlate #(
  parameter int DIR_ENTRIES = 64,
  parameter int CACHE_WAYS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_base_i,
  input  logic [7:0]  cfg_size_i,
  input  logic        dir_wr_i,
  input  logic [31:0] dir_wdata_i,
  input  logic        ctl_wr_i,
  input  logic [31:0] ctl_wdata_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [31:0] rsp_addr_o,
  output logic        rsp_fault_o,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [31:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i
);
  import xl_pkg::*;
  localparam int IDX_W = $clog2(DIR_ENTRIES);
  localparam int PG_W  = 20;

  xl_state_t   state_q;
  logic [31:0] req_q;
  logic [31:0] res_addr_q;
  logic        res_fault_q;
  logic        ctl_b7_q;
  logic        flush_pend;
  logic        flush_now;

  logic [9:0]      dir_off;
  logic            in_range;
  logic            dir_present;
  logic [PG_W-1:0] dir_tbl;
  logic            hit;
  logic [PG_W-1:0] hit_frame;
  logic            fill_en;

  logic unused_bits;
  assign unused_bits = ^{dir_wdata_i[11:6], cfg_base_i[21:0], ctl_wdata_i[31:8],
                         ctl_wdata_i[6:0], mem_rsp_data_i[11:1], dir_off[9:IDX_W]};

  // directory offset and range test
  assign dir_off  = req_q[31:22] - cfg_base_i[31:22];
  assign in_range = {2'b00, dir_off} < {4'b0000, size_limit(cfg_size_i, DIR_ENTRIES)};

  xl_dir #(.ENTRIES(DIR_ENTRIES), .TBL_W(PG_W)) i_dir (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dir_wr_i), .wr_idx(dir_wdata_i[IDX_W-1:0]),
    .wr_present(dir_wdata_i[8]), .wr_tbl(dir_wdata_i[31:12]),
    .rd_idx(dir_off[IDX_W-1:0]), .rd_present(dir_present), .rd_tbl(dir_tbl)
  );

  assign fill_en = (state_q == ST_MWAIT) && mem_rsp_valid_i && mem_rsp_data_i[0];

  xl_tcache #(.WAYS(CACHE_WAYS), .TAG_W(PG_W), .DATA_W(PG_W)) i_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush_now),
    .lk_tag(req_q[31:12]), .lk_hit(hit), .lk_data(hit_frame),
    .fill_en(fill_en), .fill_tag(req_q[31:12]), .fill_data(mem_rsp_data_i[31:12])
  );

  // flush control: a rising bit 7 arms a flush applied while idle
  assign flush_now = flush_pend && (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_b7_q   <= 1'b0;
      flush_pend <= 1'b0;
    end else begin
      if (ctl_wr_i) ctl_b7_q <= ctl_wdata_i[7];
      if (ctl_wr_i && ctl_wdata_i[7] && !ctl_b7_q) flush_pend <= 1'b1;
      else if (flush_now)                           flush_pend <= 1'b0;
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE) && !flush_pend;
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_addr_o      = res_addr_q;
  assign rsp_fault_o     = res_fault_q;
  assign mem_req_valid_o = (state_q == ST_MREQ);
  assign mem_req_addr_o  = {dir_tbl, req_q[21:12], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_q       <= '0;
      res_addr_q  <= '0;
      res_fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i && req_ready_o) begin
          req_q   <= req_addr_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!in_range || !dir_present) begin
            res_addr_q  <= '0;
            res_fault_q <= 1'b1;
            state_q     <= ST_RESP;
          end else if (hit) begin
            res_addr_q  <= {hit_frame, req_q[11:0]};
            res_fault_q <= 1'b0;
            state_q     <= ST_RESP;
          end else begin
            state_q <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready_i) state_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid_i) begin
          res_fault_q <= !mem_rsp_data_i[0];
          res_addr_q  <= mem_rsp_data_i[0] ? {mem_rsp_data_i[31:12], req_q[11:0]} : 32'd0;
          state_q     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xl_chk.sv
module xl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_addr,
  input logic        rsp_fault,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        flush_pend
);
  // R9: response held under back-pressure
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));
  // R9: memory request held until taken
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R9: single request in flight
  a_r9_one_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);
  // R9: no response while memory read is requested
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid);
  // R8: requests stall while a flush is pending
  a_r8_flush_stall: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend |-> !req_ready);
  // R6: fault responses carry a zero address
  a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_addr == 32'd0);
endmodule

bind aper_xlate xl_chk i_xl_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready_o),
  .rsp_valid(rsp_valid_o), .rsp_ready(rsp_ready_i),
  .rsp_addr(rsp_addr_o), .rsp_fault(rsp_fault_o),
  .mem_req_valid(mem_req_valid_o), .mem_req_ready(mem_req_ready_i),
  .mem_req_addr(mem_req_addr_o), .flush_pend(flush_pend)
);

// File: tb/test_aper_xlate.sv
module test_aper_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = 32'h4000_0000;
  logic [7:0]  cfg_size = 8'd0;
  logic        dir_wr = 1'b0;
  logic [31:0] dir_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aper_xlate i_aper_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_base_i(cfg_base), .cfg_size_i(cfg_size),
    .dir_wr_i(dir_wr), .dir_wdata_i(dir_wdata), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_addr_o(rsp_addr),
    .rsp_fault_o(rsp_fault), .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic dir_load(logic [31:0] v);
    @(negedge clk); dir_wr = 1'b1; dir_wdata = v;
    @(negedge clk); dir_wr = 1'b0;
  endtask

  task automatic ctl_write(logic [31:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  // one translation; results sampled at fixed cycles (R10)
  task automatic xlate(string req, logic [31:0] a, bit exp_mem, logic [31:0] exp_maddr,
                       logic [31:0] mdata, bit exp_fault, logic [31:0] exp_res);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    chk(req, "req_ready", 32'(req_ready), 32'd1);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    if (exp_mem) begin
      chk(req, "mem_req_valid", 32'(mem_req_valid), 32'd1);
      chk(req, "mem_req_addr", mem_req_addr, exp_maddr);
      chk(req, "rsp_valid early", 32'(rsp_valid), 32'd0);
      @(negedge clk);
      chk(req, "single read", 32'(mem_req_valid), 32'd0);
      mem_rsp_valid = 1'b1; mem_rsp_data = mdata;
      @(negedge clk); mem_rsp_valid = 1'b0;
    end else begin
      chk(req, "no mem read", 32'(mem_req_valid), 32'd0);
    end
    chk(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, "rsp_fault", 32'(rsp_fault), 32'(exp_fault));
    chk(req, "rsp_addr", rsp_addr, exp_res);
    @(negedge clk);
    chk(req, "rsp taken", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);
    xlate("R1", 32'h4000_0123, 1'b0, 0, 0, 1'b1, 32'd0);
  endtask

  task automatic t_basic;
    // dir 0: table 0x00100, present, attr 3, reserved bits set (R2)
    dir_load(32'h0010_0000 | 32'h600 | 32'h100 | 32'hC0 | 32'd0);
    dir_load(32'h0020_0000 | 32'h100 | 32'd5);
    xlate("R4", 32'h4000_3ABC, 1'b1, 32'h0010_000C, 32'h1234_5001, 1'b0, 32'h1234_5ABC);
    xlate("R7", 32'h4000_3123, 1'b0, 0, 0, 1'b0, 32'h1234_5123);
    xlate("R5", 32'h4000_4000, 1'b1, 32'h0010_0010, 32'h5555_5000, 1'b1, 32'd0);
    xlate("R7", 32'h4000_4000, 1'b1, 32'h0010_0010, 32'h5555_5000, 1'b1, 32'd0);
    xlate("R2", 32'h4140_7FFF, 1'b1, 32'h0020_001C, 32'hABCD_E001, 1'b0, 32'hABCD_EFFF);
    xlate("R2", 32'h4240_0000, 1'b0, 0, 0, 1'b1, 32'd0);
    dir_load(32'h0000_0005);
    xlate("R2", 32'h4140_8000, 1'b0, 0, 0, 1'b1, 32'd0);
  endtask

  task automatic t_range;
    dir_load(32'h0030_0000 | 32'h100 | 32'd8);
    cfg_size = 8'd56;
    xlate("R3", 32'h4200_1000, 1'b0, 0, 0, 1'b1, 32'd0);
    cfg_size = 8'd48;
    xlate("R3", 32'h4200_1000, 1'b1, 32'h0030_0004, 32'h7777_7001, 1'b0, 32'h7777_7000);
    xlate("R3", 32'h3FC0_0000, 1'b0, 0, 0, 1'b1, 32'd0);
    cfg_size = 8'd7;
    xlate("R3", 32'h4000_3000, 1'b0, 0, 0, 1'b1, 32'd0);
    cfg_size = 8'd0;
  endtask

  task automatic t_flush;
    ctl_write(32'h2200);
    ctl_write(32'h2280);
    chk("R8", "stall during flush", 32'(req_ready), 32'd0);
    xlate("R8", 32'h4000_3000, 1'b1, 32'h0010_000C, 32'h1234_5001, 1'b0, 32'h1234_5000);
    ctl_write(32'h2280);
    chk("R8", "no flush without rise", 32'(req_ready), 32'd1);
    xlate("R8", 32'h4000_3004, 1'b0, 0, 0, 1'b0, 32'h1234_5004);
  endtask

  task automatic t_round_robin;
    ctl_write(32'h2200);
    ctl_write(32'h2280);
    for (int i = 0; i < 5; i++)
      xlate("R7", 32'h4001_0000 + 32'(i << 12), 1'b1, 32'h0010_0040 + 32'(i * 4),
            32'hA000_0001 + 32'(i << 12), 1'b0, 32'hA000_0000 + 32'(i << 12));
    xlate("R7", 32'h4001_3000, 1'b0, 0, 0, 1'b0, 32'hA000_3000);
    xlate("R7", 32'h4001_0000, 1'b1, 32'h0010_0040, 32'hA000_0001, 1'b0, 32'hA000_0000);
    xlate("R7", 32'h4001_2000, 1'b0, 0, 0, 1'b0, 32'hA000_2000);
    xlate("R7", 32'h4001_1000, 1'b1, 32'h0010_0044, 32'hA000_1001, 1'b0, 32'hA000_1000);
  endtask

  task automatic t_backpressure;
    rsp_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_addr = 32'h4240_0000;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "fault rsp at E1", 32'(rsp_valid), 32'd1);
    chk("R6", "fault flag", 32'(rsp_fault), 32'd1);
    @(negedge clk); @(negedge clk);
    chk("R9", "rsp held", 32'(rsp_valid), 32'd1);
    chk("R9", "req_ready low", 32'(req_ready), 32'd0);
    chk("R6", "addr zero", rsp_addr, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9", "rsp released", 32'(rsp_valid), 32'd0);
    chk("R9", "ready again", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_range();
    t_flush();
    t_round_robin();
    t_backpressure();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule